// File: doc/BRIEF.md
# Field-Aware Active-Window Blanking Generator

This block drives a composite blanking request that frames the active picture inside interlaced video timing. It runs on the pixel clock and takes one-cycle strobes for horizontal and vertical sync from the timing generator beside it. It counts pixel clocks since the last horizontal strobe and lines since the last vertical strobe. The request is raised only where both counts fall inside a programmed window.

The vertical window depends on the field. The odd field and the even field each have their own start offset. When the colour lookup table is not being loaded, the window starts two lines later. The window height is the programmed line register plus the even-field offset minus the odd-field offset. All settings, the field identifier and the lookup-load flag are captured at the vertical strobe, so a field never runs on a mix of old and new values.

Top module: `field_window_blanker`

## Requirements
- R1: `blankReq` is 0 while `rstN` is low (reset is asynchronous). After reset it stays 0 until a vertical strobe has captured a set of settings.
- R2: Let edge k be the clock edge that samples `hsyncStrobe`=1. On an active line, `blankReq` is 1 after edges k+`hOffset`+1 through k+`hOffset`+2·`halfPixels` and 0 at every other position of that line. When `halfPixels`=0, no pulse is produced.
- R3: The line that begins at the horizontal strobe sampled together with the vertical strobe is line 0. In the odd field (`fieldIsEven`=0) with `lutRequest`=1, the first active line is line `vOffOdd`.
- R4: In the even field (`fieldIsEven`=1) with `lutRequest`=1, the first active line is line `vOffEven`.
- R5: With `lutRequest`=0 (no table data wanted), the first active line is the selected field offset plus 2.
- R6: The number of active lines is `lineReq` + `vOffEven` − `vOffOdd`. When that sum is zero or negative, no line is active.
- R7: All register inputs, `fieldIsEven` and `lutRequest` take effect only at the edge that samples `vsyncStrobe`=1. Changes made between vertical strobes do not affect the current field.
- R8: The pixel counter saturates at its maximum and does not wrap. On a line with no further horizontal strobe, only one pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hsyncStrobe | input | 1 | One-cycle horizontal sync strobe; starts a line |
| vsyncStrobe | input | 1 | One-cycle vertical sync strobe; starts a field and captures settings |
| fieldIsEven | input | 1 | 1 = even field, 0 = odd field; sampled at the vertical strobe |
| lutRequest | input | 1 | 1 = table data requested (no start shift); sampled at the vertical strobe |
| hOffset | input | PIX_W | Pixel clocks from horizontal strobe to pulse start |
| halfPixels | input | PIX_W-1 | Half the pulse length in pixel clocks |
| vOffOdd | input | LINE_W | First active line in the odd field |
| vOffEven | input | LINE_W | First active line in the even field |
| lineReq | input | LINE_W | Base line count of the vertical window |
| blankReq | output | 1 | Composite blanking request |

## Verification
The assertions assume single-cycle strobes. They also assume that horizontal strobes arrive further apart than `hOffset` + 2·`halfPixels` cycles, so the pulse-length bound is never broken by a line that is shorter than its own window. The bench drives every strobe as a single cycle and uses lines of 40 clocks with windows that end by position 38. The one exception is the saturation case, where a single line runs for 4300 clocks. The bench changes register inputs only on falling edges, either between fields or at a chosen line inside a field.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  // Strobes and qualifiers passed from the vertical control to the horizontal datapath
  typedef struct packed {
    logic pixClear;      // restart the pixel count
    logic loadShadow;    // capture horizontal settings
    logic lineInWindow;  // current line is inside the active vertical window
  } fwb_strobe_t;
endpackage

// File: rtl/fwb_ctrl.sv
module fwb_ctrl
  import fwb_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsyncStrobe,
  input  logic              vsyncStrobe,
  input  logic              fieldIsEven,
  input  logic              lutRequest,
  input  logic [LINE_W-1:0] vOffOdd,
  input  logic [LINE_W-1:0] vOffEven,
  input  logic [LINE_W-1:0] lineReq,
  output fwb_strobe_t       strobes
);
  localparam int SUM_W = LINE_W + 2;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [LINE_W-1:0]        lineCnt;
  logic [SUM_W-1:0]         startS, endS;
  logic [SUM_W-1:0]         startNext, endNext, countNext;
  logic signed [SUM_W-1:0]  diffNext;
  logic [LINE_W-1:0]        selOff;

  // Vertical window derived from the inputs present at the vertical strobe
  always_comb begin
    selOff    = fieldIsEven ? vOffEven : vOffOdd;
    startNext = SUM_W'(selOff) + (lutRequest ? SUM_W'(0) : SUM_W'(2));
    diffNext  = $signed(SUM_W'(lineReq)) + $signed(SUM_W'(vOffEven))
              - $signed(SUM_W'(vOffOdd));
    countNext = (diffNext < 0) ? '0 : SUM_W'(diffNext);
    endNext   = startNext + countNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startS <= '0;
      endS   <= '0;
    end else if (vsyncStrobe) begin
      startS <= startNext;
      endS   <= endNext;
    end
  end

  // Line counter: cleared by vertical strobe, advanced by horizontal strobe, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCnt <= '0;
    end else if (vsyncStrobe) begin
      lineCnt <= '0;
    end else if (hsyncStrobe && (lineCnt != LINE_MAX)) begin
      lineCnt <= lineCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.pixClear     = hsyncStrobe;
    strobes.loadShadow   = vsyncStrobe;
    strobes.lineInWindow = (SUM_W'(lineCnt) >= startS) && (SUM_W'(lineCnt) < endS);
  end

  // R3: the line after a vertical strobe is numbered zero
  p_line_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    vsyncStrobe |=> (lineCnt == '0));

  // R7: the vertical window only changes at a vertical strobe
  p_vwin_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !vsyncStrobe |=> ($stable(startS) && $stable(endS)));

  // R6: a window never ends before it starts
  p_win_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    vsyncStrobe |=> (endS >= startS));
endmodule

// File: rtl/fwb_datapath.sv
module fwb_datapath
  import fwb_pkg::*;
#(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  fwb_strobe_t      strobes,
  input  logic [PIX_W-1:0] hOffset,
  input  logic [PIX_W-2:0] halfPixels,
  output logic             blankReq
);
  localparam int SPAN_W = PIX_W + 1;
  localparam logic [PIX_W-1:0] PIX_MAX = '1;

  logic [PIX_W-1:0]  pixCnt;
  logic [PIX_W-1:0]  hOffS;
  logic [PIX_W-2:0]  halfS;
  logic [SPAN_W-1:0] spanEnd;
  logic              pixInWindow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hOffS <= '0;
      halfS <= '0;
    end else if (strobes.loadShadow) begin
      hOffS <= hOffset;
      halfS <= halfPixels;
    end
  end

  // Pixel counter: cleared by horizontal strobe, saturating otherwise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCnt <= '0;
    end else if (strobes.pixClear) begin
      pixCnt <= '0;
    end else if (pixCnt != PIX_MAX) begin
      pixCnt <= pixCnt + 1'b1;
    end
  end

  always_comb begin
    spanEnd     = SPAN_W'(hOffS) + SPAN_W'({halfS, 1'b0});
    pixInWindow = (SPAN_W'(pixCnt) >= SPAN_W'(hOffS)) && (SPAN_W'(pixCnt) < spanEnd);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blankReq <= 1'b0;
    end else begin
      blankReq <= strobes.lineInWindow && pixInWindow;
    end
  end

  // Checker state: length of the current high run of the request
  logic [SPAN_W-1:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen <= '0;
    end else if (blankReq) begin
      runLen <= runLen + 1'b1;
    end else begin
      runLen <= '0;
    end
  end

  // R1: request quiet whenever reset is applied
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (!blankReq);
    end
  end

  // R2: pixel count restarts at the horizontal strobe
  p_pix_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pixClear |=> (pixCnt == '0));

  // R2: a pulse never lasts longer than twice the half-length setting
  p_span_limit_r2: assert property (@(posedge clk) disable iff (!rstN)
    blankReq |-> (runLen < SPAN_W'({halfS, 1'b0})));

  // R7: horizontal settings change only at the vertical strobe
  p_hwin_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadShadow |=> ($stable(hOffS) && $stable(halfS)));

  // R8: the pixel counter never wraps from its maximum
  p_pix_sat_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pixCnt == PIX_MAX && !strobes.pixClear) |=> (pixCnt == PIX_MAX));
endmodule

// File: rtl/field_window_blanker.sv
module field_window_blanker
  import fwb_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsyncStrobe,
  input  logic              vsyncStrobe,
  input  logic              fieldIsEven,
  input  logic              lutRequest,
  input  logic [PIX_W-1:0]  hOffset,
  input  logic [PIX_W-2:0]  halfPixels,
  input  logic [LINE_W-1:0] vOffOdd,
  input  logic [LINE_W-1:0] vOffEven,
  input  logic [LINE_W-1:0] lineReq,
  output logic              blankReq
);
  fwb_strobe_t strobes;

  fwb_ctrl #(.LINE_W(LINE_W)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .hsyncStrobe (hsyncStrobe),
    .vsyncStrobe (vsyncStrobe),
    .fieldIsEven (fieldIsEven),
    .lutRequest  (lutRequest),
    .vOffOdd     (vOffOdd),
    .vOffEven    (vOffEven),
    .lineReq     (lineReq),
    .strobes     (strobes)
  );

  fwb_datapath #(.PIX_W(PIX_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .hOffset    (hOffset),
    .halfPixels (halfPixels),
    .blankReq   (blankReq)
  );
endmodule

// File: tb/field_window_blanker_tb.sv
`timescale 1ns/1ps
module field_window_blanker_tb_top;
  localparam int PIX_W  = 12;
  localparam int LINE_W = 10;
  localparam int LLEN   = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hsyncStrobe = 1'b0, vsyncStrobe = 1'b0;
  logic fieldIsEven = 1'b0, lutRequest = 1'b1;
  logic [PIX_W-1:0]  hOffset = '0;
  logic [PIX_W-2:0]  halfPixels = '0;
  logic [LINE_W-1:0] vOffOdd = '0, vOffEven = '0, lineReq = '0;
  logic blankReq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Expected configuration
  int eHOff, eHalf, eVOO, eVOE, eYpix;
  bit eEven, eLut;
  // Alternate configuration applied mid-field
  int aHOff, aHalf, aVOO, aVOE, aYpix;
  bit aEven, aLut;

  always #2 clk = ~clk;

  field_window_blanker #(.PIX_W(PIX_W), .LINE_W(LINE_W)) dut_i (
    .clk(clk), .rstN(rstN), .hsyncStrobe(hsyncStrobe), .vsyncStrobe(vsyncStrobe),
    .fieldIsEven(fieldIsEven), .lutRequest(lutRequest), .hOffset(hOffset),
    .halfPixels(halfPixels), .vOffOdd(vOffOdd), .vOffEven(vOffEven),
    .lineReq(lineReq), .blankReq(blankReq)
  );

  task automatic chk(input bit got, input bit exp, input string tag, input int l, input int j);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s line %0d pos %0d: blankReq=%0b expected %0b", tag, l, j, got, exp);
    end
  endtask

  function automatic bit expWin(input int l, input int j);
    int start, cnt;
    start = (eEven ? eVOE : eVOO) + (eLut ? 0 : 2);
    cnt = eYpix + eVOE - eVOO;
    if (cnt < 0) cnt = 0;
    return (l >= start) && (l < start + cnt) && (j >= eHOff + 1) && (j <= eHOff + 2 * eHalf);
  endfunction

  task automatic setCfg(input int ho, input int hp, input int vo, input int ve,
                        input int yp, input bit ev, input bit lu);
    eHOff = ho; eHalf = hp; eVOO = vo; eVOE = ve; eYpix = yp; eEven = ev; eLut = lu;
    @(negedge clk);
    hOffset = PIX_W'(ho); halfPixels = (PIX_W-1)'(hp);
    vOffOdd = LINE_W'(vo); vOffEven = LINE_W'(ve); lineReq = LINE_W'(yp);
    fieldIsEven = ev; lutRequest = lu;
  endtask

  task automatic runFrame(input int nLines, input int lineLen, input bit chg,
                          input int chgLine, input string tag);
    for (int l = 0; l < nLines; l++) begin
      for (int j = 0; j < lineLen; j++) begin
        @(negedge clk);
        hsyncStrobe = (j == 0);
        vsyncStrobe = (l == 0) && (j == 0);
        if (chg && l == chgLine && j == 0) begin
          hOffset = PIX_W'(aHOff); halfPixels = (PIX_W-1)'(aHalf);
          vOffOdd = LINE_W'(aVOO); vOffEven = LINE_W'(aVOE); lineReq = LINE_W'(aYpix);
          fieldIsEven = aEven; lutRequest = aLut;
        end
        @(posedge clk); #1;
        if (j >= 1) chk(blankReq, expWin(l, j), tag, l, j);
        else if (l >= 1) chk(blankReq, expWin(l - 1, lineLen), tag, l - 1, lineLen);
      end
    end
    @(negedge clk);
    hsyncStrobe = 1'b0; vsyncStrobe = 1'b0;
  endtask

  // Horizontal strobes only, no vertical strobe: expect silence
  task automatic quietLines(input int nLines, input string tag);
    for (int l = 0; l < nLines; l++) begin
      for (int j = 0; j < LLEN; j++) begin
        @(negedge clk);
        hsyncStrobe = (j == 0);
        @(posedge clk); #1;
        chk(blankReq, 1'b0, tag, l, j);
      end
    end
    @(negedge clk);
    hsyncStrobe = 1'b0;
  endtask

  task automatic test_reset();
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      chk(blankReq, 1'b0, "R1 during reset", 0, i);
    end
    setCfg(2, 4, 0, 0, 5, 0, 1);
    @(negedge clk) rstN = 1'b1;
    quietLines(3, "R1 before first vsync");
  endtask

  task automatic test_odd_field();
    setCfg(5, 6, 3, 3, 4, 0, 1);
    runFrame(10, LLEN, 0, 0, "R2 R3 odd field");
  endtask

  task automatic test_no_lut();
    setCfg(5, 6, 3, 3, 4, 0, 0);
    runFrame(10, LLEN, 0, 0, "R5 no table shift");
  endtask

  task automatic test_even_field();
    setCfg(3, 5, 2, 4, 3, 1, 1);
    runFrame(12, LLEN, 0, 0, "R4 R6 even field");
  endtask

  task automatic test_odd_diff();
    setCfg(3, 5, 2, 4, 3, 0, 1);
    runFrame(10, LLEN, 0, 0, "R6 odd field count");
    setCfg(7, 3, 1, 6, 2, 1, 0);
    runFrame(14, LLEN, 0, 0, "R4 R5 R6 even shifted");
  endtask

  task automatic test_negative_count();
    setCfg(4, 4, 5, 2, 1, 0, 1);
    runFrame(10, LLEN, 0, 0, "R6 negative count");
    setCfg(4, 4, 3, 3, 0, 1, 1);
    runFrame(8, LLEN, 0, 0, "R6 zero count");
  endtask

  task automatic test_latch();
    setCfg(4, 5, 2, 2, 4, 0, 1);
    aHOff = 10; aHalf = 3; aVOO = 1; aVOE = 3; aYpix = 2; aEven = 1; aLut = 0;
    runFrame(10, LLEN, 1, 3, "R7 mid-field change ignored");
    eHOff = aHOff; eHalf = aHalf; eVOO = aVOO; eVOE = aVOE; eYpix = aYpix;
    eEven = aEven; eLut = aLut;
    runFrame(10, LLEN, 0, 0, "R7 change taken at vsync");
  endtask

  task automatic test_horizontal_edges();
    setCfg(0, 7, 1, 1, 2, 0, 1);
    runFrame(5, LLEN, 0, 0, "R2 zero offset");
    setCfg(6, 0, 0, 0, 4, 0, 1);
    runFrame(5, LLEN, 0, 0, "R2 zero length");
    setCfg(36, 1, 0, 0, 2, 0, 1);
    runFrame(4, LLEN, 0, 0, "R2 late pulse");
  endtask

  task automatic test_saturation();
    setCfg(5, 2, 0, 0, 1, 0, 1);
    runFrame(1, 4300, 0, 0, "R8 no counter wrap");
  endtask

  task automatic test_reset_mid_pulse();
    setCfg(4, 8, 0, 0, 3, 0, 1);
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      hsyncStrobe = (j == 0);
      vsyncStrobe = (j == 0);
    end
    @(negedge clk);
    hsyncStrobe = 1'b0; vsyncStrobe = 1'b0;
    #1;
    chk(blankReq, 1'b1, "R2 pulse before reset", 0, 11);
    rstN = 1'b0;
    #1;
    chk(blankReq, 1'b0, "R1 async reset mid pulse", 0, 11);
    @(negedge clk) rstN = 1'b1;
    quietLines(2, "R1 settings cleared by reset");
  endtask

  initial begin
    test_reset();
    test_odd_field();
    test_no_lut();
    test_even_field();
    test_odd_diff();
    test_negative_count();
    test_latch();
    test_horizontal_edges();
    test_saturation();
    test_reset_mid_pulse();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule